// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Flags

This block holds two byte-wide accumulators and a five-bit condition register, and runs one arithmetic or logic operation per clock on request. The destination accumulator is chosen by a select input. The second operand is either an immediate byte or the other accumulator. The operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR and exclusive OR. The result goes back into the destination accumulator; compare writes nothing. The condition register is updated according to the rules of each operation.

The two accumulators can also be read and loaded together as one double-width register. The first accumulator is the high byte. A combinational result output shows what the pending operation would produce before the clock edge. The operand width is a parameter. The half-carry flag is taken from the carry into the upper half of the word.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset, both accumulators are zero and all five flags are zero.
- R2: Op code 0 (add) and op code 1 (add with carry) write destination plus operand, plus the incoming C flag for op code 1, modulo 256. C is set on a carry out of bit 7.
- R3: Op code 2 (subtract) and op code 3 (subtract with borrow) write destination minus operand, minus the incoming C flag for op code 3, modulo 256. C is set when an unsigned borrow occurs.
- R4: V is set when the signed two's-complement result of an add, subtract or compare falls outside -128..127. For example, 0xAB + 0xA6 gives 0x51 with V and C both set.
- R5: After any executed operation, Z is set exactly when the 8-bit result is zero, and N equals bit 7 of the result.
- R6: H is set by op codes 0 and 1 when there is a carry from bit 3 into bit 4. Every other op code leaves H unchanged.
- R7: Op code 4 (compare) updates N, Z, V and C as a subtract would, and writes neither accumulator.
- R8: Op codes 5, 6 and 7 (AND, OR, exclusive OR) write the bitwise result, clear V, update N and Z, and leave C and H unchanged.
- R9: acc_d always equals {acc_a, acc_b}. A cycle with d_wr_en high loads acc_a from d_wr_data[15:8] and acc_b from d_wr_data[7:0]. Any execute request in that same cycle is ignored, and the flags are kept.
- R10: dst_sel = 0 selects acc_a as destination and dst_sel = 1 selects acc_b. The operand is imm_data when use_imm is 1, and otherwise the accumulator that is not the destination.
- R11: In a cycle with neither exec nor d_wr_en, both accumulators and the flags hold their values.
- R12: The flags output packs C in bit 0, V in bit 1, Z in bit 2, N in bit 3 and H in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Perform the operation this cycle |
| op_code | input | 3 | Operation select (0 add ... 7 exclusive OR) |
| dst_sel | input | 1 | Destination: 0 first accumulator, 1 second |
| use_imm | input | 1 | Operand is imm_data rather than the other accumulator |
| imm_data | input | 8 | Immediate operand |
| d_wr_en | input | 1 | Load both accumulators as one word |
| d_wr_data | input | 16 | Word for the double load |
| alu_result | output | 8 | Combinational result of the pending operation |
| acc_a | output | 8 | First accumulator |
| acc_b | output | 8 | Second accumulator |
| acc_d | output | 16 | Both accumulators, first one high |
| flags | output | 5 | Condition register {H,N,Z,V,C} |

## Verification
The bench builds the block with the default 8-bit width and the split half-word adder. At that width the signed limits 0x7F and 0x80, the half-carry boundary at 0x0F and the unsigned wrap at 0xFF can all be hit directly, and random operand pairs cover every carry and borrow combination quickly. The random mix reuses the flag state each operation leaves behind, so carry-in and borrow-in chains across consecutive operations are exercised. It also includes double loads that collide with execute requests.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_CMP = 3'd4,
      OP_AND = 3'd5,
      OP_ORR = 3'd6,
      OP_XOR = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } cond_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int  W         = 8,
   parameter bit  SPLIT_ADD = 1'b1
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         chalf,
   output logic         ovf
);
   localparam int H = W / 2;

   logic [W-1:0] msb_in;
   logic         c_msb;

   assign msb_in = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin};
   assign c_msb  = msb_in[W-1];

   generate
      if (SPLIT_ADD) begin : g_split
         logic [H:0]   lo;
         logic [W-H:0] hi;
         assign lo    = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, cin};
         assign hi    = {1'b0, x[W-1:H]} + {1'b0, y[W-1:H]} + {{(W-H){1'b0}}, lo[H]};
         assign sum   = {hi[W-H-1:0], lo[H-1:0]};
         assign cout  = hi[W-H];
         assign chalf = lo[H];
      end else begin : g_wide
         logic [W:0] full;
         logic [H:0] lo;
         assign full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
         assign lo    = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, cin};
         assign sum   = full[W-1:0];
         assign cout  = full[W];
         assign chalf = lo[H];
      end
   endgenerate

   assign ovf = c_msb ^ cout;
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int W         = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  alu_op_e      op,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  cond_t        f_in,
   output logic [W-1:0] res,
   output cond_t        f_out,
   output logic         wr_res
);
   logic         is_sub, is_add, is_logic;
   logic [W-1:0] y_eff, a_sum;
   logic         a_cin, a_cout, a_half, a_ovf;

   assign is_add   = (op == OP_ADD) || (op == OP_ADC);
   assign is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
   assign is_logic = !(is_add || is_sub);
   assign y_eff    = is_sub ? ~y : y;

   always_comb begin
      unique case (op)
         OP_ADC:  a_cin = f_in.c;
         OP_SUB:  a_cin = 1'b1;
         OP_CMP:  a_cin = 1'b1;
         OP_SBC:  a_cin = ~f_in.c;
         default: a_cin = 1'b0;
      endcase
   end

   alu_adder #(.W(W), .SPLIT_ADD(SPLIT_ADD)) u_add (
      .x(x), .y(y_eff), .cin(a_cin),
      .sum(a_sum), .cout(a_cout), .chalf(a_half), .ovf(a_ovf)
   );

   always_comb begin
      unique case (op)
         OP_AND:  res = x & y;
         OP_ORR:  res = x | y;
         OP_XOR:  res = x ^ y;
         default: res = a_sum;
      endcase
   end

   always_comb begin
      f_out.n = res[W-1];
      f_out.z = (res == '0);
      f_out.h = is_add ? a_half : f_in.h;
      f_out.v = is_logic ? 1'b0 : a_ovf;
      f_out.c = is_logic ? f_in.c : (is_sub ? ~a_cout : a_cout);
   end

   assign wr_res = (op != OP_CMP);
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_a,
   input  logic           wr_b,
   input  logic [W-1:0]   wdata,
   input  logic           d_wr,
   input  logic [2*W-1:0] d_data,
   output logic [W-1:0]   a_q,
   output logic [W-1:0]   b_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (d_wr) begin
         a_q <= d_data[2*W-1:W];
         b_q <= d_data[W-1:0];
      end else begin
         if (wr_a) a_q <= wdata;
         if (wr_b) b_q <= wdata;
      end
   end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
   import alu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                exec,
   input  logic [2:0]          op_code,
   input  logic                dst_sel,
   input  logic                use_imm,
   input  logic [DATA_W-1:0]   imm_data,
   input  logic                d_wr_en,
   input  logic [2*DATA_W-1:0] d_wr_data,
   output logic [DATA_W-1:0]   alu_result,
   output logic [DATA_W-1:0]   acc_a,
   output logic [DATA_W-1:0]   acc_b,
   output logic [2*DATA_W-1:0] acc_d,
   output logic [4:0]          flags
);
   localparam int DW = 2 * DATA_W;

   generate
      if ((DATA_W < 4) || (DATA_W % 2 != 0)) begin : g_bad_width
         $error("acc_alu_unit: DATA_W must be even and at least 4");
      end
   endgenerate

   alu_op_e            op;
   cond_t              f_q, f_next;
   logic [DATA_W-1:0]  dst_v, src_v;
   logic               do_op, core_wr;

   assign op    = alu_op_e'(op_code);
   assign do_op = exec && !d_wr_en;
   assign dst_v = dst_sel ? acc_b : acc_a;
   assign src_v = use_imm ? imm_data : (dst_sel ? acc_a : acc_b);

   alu_core #(.W(DATA_W), .SPLIT_ADD(SPLIT_ADD)) u_core (
      .op(op), .x(dst_v), .y(src_v), .f_in(f_q),
      .res(alu_result), .f_out(f_next), .wr_res(core_wr)
   );

   acc_regfile #(.W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_a(do_op && core_wr && !dst_sel),
      .wr_b(do_op && core_wr && dst_sel),
      .wdata(alu_result),
      .d_wr(d_wr_en), .d_data(d_wr_data),
      .a_q(acc_a), .b_q(acc_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     f_q <= '0;
      else if (do_op) f_q <= f_next;
   end

   assign flags = f_q;
   assign acc_d = {acc_a, acc_b};

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (do_op && op == OP_CMP) |=> ($stable(acc_a) && $stable(acc_b))); // R7
   AST_H_ADD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (do_op && op != OP_ADD && op != OP_ADC) |=> $stable(f_q.h)); // R6
   AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (do_op && (op == OP_AND || op == OP_ORR || op == OP_XOR)) |=> (!f_q.v && $stable(f_q.c))); // R8
   AST_D_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      d_wr_en |=> (acc_d == $past(d_wr_data) && $stable(f_q))); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec && !d_wr_en) |=> ($stable(acc_a) && $stable(acc_b) && $stable(f_q))); // R11
   AST_Z_N_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      do_op |=> (f_q.z == ($past(alu_result) == '0) && f_q.n == $past(alu_result[DATA_W-1]))); // R5
   AST_WIDE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      acc_d[DW-1:DATA_W] == acc_a); // R9
endmodule

// File: tb/sim_acc_alu_unit.sv
module sim_acc_alu_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec = 1'b0;
   logic [2:0]  op_code = '0;
   logic        dst_sel = 1'b0;
   logic        use_imm = 1'b0;
   logic [7:0]  imm_data = '0;
   logic        d_wr_en = 1'b0;
   logic [15:0] d_wr_data = '0;
   logic [7:0]  alu_result, acc_a, acc_b;
   logic [15:0] acc_d;
   logic [4:0]  flags;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_a, m_b;
   logic [4:0] m_f;

   always #4 clk = ~clk;

   acc_alu_unit u0 (.*);

   // returns {result, H, N, Z, V, C}
   function automatic logic [12:0] model(input logic [2:0] op, input logic [7:0] x,
                                         input logic [7:0] y, input logic [4:0] f);
      int ux, uy, sx, sy, s, ss, k;
      logic [7:0] r;
      logic h, v, c;
      ux = int'(x); uy = int'(y);
      sx = int'($signed(x)); sy = int'($signed(y));
      h = f[4]; c = f[0]; v = 1'b0;
      if (op <= 3'd1) begin
         k = (op == 3'd1) ? int'(f[0]) : 0;
         s = ux + uy + k; ss = sx + sy + k;
         r = s[7:0]; c = (s > 255);
         h = ((ux % 16) + (uy % 16) + k) > 15;
         v = (ss > 127) || (ss < -128);
      end else if (op <= 3'd4) begin
         k = (op == 3'd3) ? int'(f[0]) : 0;
         s = ux - uy - k; ss = sx - sy - k;
         r = s[7:0]; c = (s < 0);
         v = (ss > 127) || (ss < -128);
      end else begin
         case (op)
            3'd5:    r = x & y;
            3'd6:    r = x | y;
            default: r = x ^ y;
         endcase
      end
      return {r, h, r[7], (r == 8'd0), v, c};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R2 R3 R4 R5 R6 R7 R8 R10 R11 R9: one cycle, checked against the model
   task automatic step(input logic ex, input logic [2:0] op, input logic ds, input logic ui,
                       input logic [7:0] imm, input logic dw, input logic [15:0] dd,
                       input string tag);
      logic [7:0]  x, y;
      logic [12:0] e;
      exec = ex; op_code = op; dst_sel = ds; use_imm = ui; imm_data = imm;
      d_wr_en = dw; d_wr_data = dd;
      x = ds ? m_b : m_a;
      y = ui ? imm : (ds ? m_a : m_b);
      e = model(op, x, y, m_f);
      #1;
      check({tag, " result R10"}, {24'd0, alu_result}, {24'd0, e[12:5]});
      @(posedge clk);
      if (dw) begin
         m_a = dd[15:8]; m_b = dd[7:0];
      end else if (ex) begin
         m_f = e[4:0];
         if (op != 3'd4) begin
            if (ds) m_b = e[12:5]; else m_a = e[12:5];
         end
      end
      @(negedge clk);
      check({tag, " accs"}, {16'd0, acc_a, acc_b}, {16'd0, m_a, m_b});
      check({tag, " flags"}, {27'd0, flags}, {27'd0, m_f});
      check({tag, " D view R9"}, {16'd0, acc_d}, {16'd0, m_a, m_b});
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A1E));
      m_a = 0; m_b = 0; m_f = 0;
      repeat (3) @(negedge clk);
      check("R1 reset accs", {16'd0, acc_d}, 32'd0);
      check("R1 reset flags", {27'd0, flags}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      step(0, 0, 0, 0, 0, 1, 16'hABA6, "R9 load");
      step(1, 0, 0, 0, 0, 0, 0, "R4 AB+A6");
      check("R4 V and C set", {27'd0, flags & 5'b00011}, 32'd3);
      step(0, 0, 0, 0, 0, 1, 16'h7F01, "R9 load2");
      step(1, 0, 0, 0, 0, 0, 0, "R6 7F+01");
      check("R6 H set, R12 layout", {27'd0, flags}, 32'b11010);
      step(1, 2, 1, 1, 8'h02, 0, 0, "R3 01-02 borrow");
      step(1, 3, 1, 1, 8'h00, 0, 0, "R3 sbc uses C");
      step(1, 1, 0, 1, 8'h00, 0, 0, "R2 adc uses C");
      step(1, 4, 0, 1, acc_a, 0, 0, "R7 cmp equal");
      check("R7 Z set", {31'd0, flags[2]}, 32'd1);
      step(1, 5, 0, 1, 8'h00, 0, 0, "R8 and zero");
      step(1, 0, 1, 1, 8'h00, 1, 16'h8000, "R9 exec ignored");
      step(1, 2, 0, 1, 8'h01, 0, 0, "R4 80-01");
      step(0, 6, 0, 1, 8'hFF, 0, 0, "R11 idle");
      step(1, 7, 1, 0, 8'h00, 0, 0, "R8 xor from A");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[3:0] != 4'd0, r[6:4], r[7], r[8], r[23:16],
              r[12:9] == 4'd0, {r[31:24], r[23:16]}, "R2/R3/R5 random");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule